// File: doc/BRIEF.md
# Pin Bank Controller with Interrupts

This block manages a bank of general-purpose pins through a small 32-bit register bus. The bus has a byte address, write data, a write strobe and read data that is returned in the same cycle from the addressed register. Each pin owns one configuration word. That word sets whether the pin drives its pad, whether it is treated as an input, whether its interrupt is armed, and which condition on the pin counts as an event.

Three shared words serve the whole bank:
- a sticky pending-event word, cleared by writing ones;
- the synchronized pad levels;
- the values presented to the pads.

Pad inputs cross into the clock domain through a two-flop synchronizer. Event detection and the level readback both work on the synchronized value. A single interrupt line is raised while any armed pin has a pending event.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every configuration word, the pending word and the drive word read 0, no pad output enable is active and the interrupt line is low.
- R2: The configuration word of pin n is at byte offset 4*n. Writes keep bit 0 (drive enable), bit 1 (input enable), bit 2 (buffer enable), bit 3 (interrupt arm) and bits 7:5 (trigger code). Every other bit reads 0.
- R3: The output enable of pin n is active only while both its drive enable and its buffer enable are 1. The pad output of pin n equals bit n of the drive word while enabled, and is 0 otherwise.
- R4: The drive word at offset 0x88 reads back the last value written to it. Pad outputs change only in the cycle after a bus write.
- R5: The level word at offset 0x84 shows pad n in bit n. A pad change becomes visible there after two rising clock edges, and not after one.
- R6: The pending word is at offset 0x80. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: Trigger code 000 (level high) and code 001 (level low) set the pending bit on every cycle the synchronized level matches. A cleared bit therefore sets again while the level persists.
- R8: Code 010 sets the pending bit once on a rising transition, code 011 once on a falling transition, and code 100 once on either. A transition of the wrong direction sets nothing.
- R9: A pending bit is set only while the pin's interrupt arm bit is 1. The interrupt line is high exactly when some pending bit has its arm bit set. Clearing the arm bit drops the line but keeps the pending bit.
- R10: When an event sets a pending bit in the same cycle that a bus write clears that bit, the bit ends up set. Other bits named in the same write are cleared.
- R11: These accesses read 0 and change nothing: offsets above 0x88, configuration offsets of pins at or above the pin count, and any address whose two low bits are not 00.
- R12: Trigger codes 101, 110 and 111 never set a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_rdata | output | 32 | Read data of the addressed register, same cycle |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a hardware set and a bus clear landing on the same pending bit in the same cycle. The event reaches the pending word through the synchronizer and the edge register, so the bench changes the pad on a falling clock edge. It then times the clearing write so that the write commits on the third rising edge after the pad change, which is the edge on which the rising-edge event lands. In the same write, the bench clears a second bit that is already pending, which shows the clear itself took effect while the colliding bit stayed set. The re-set of a level-type bit straight after its clear is the other timing-sensitive case. The bench reads that bit in the cycle after the clear.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int unsigned CFG_W = 8;

    // Register offsets of the shared words
    localparam logic [7:0] OFS_PENDING = 8'h80;
    localparam logic [7:0] OFS_LEVEL   = 8'h84;
    localparam logic [7:0] OFS_DRIVE   = 8'h88;

    typedef enum logic [2:0] {
        TRIG_LVL_HI = 3'd0,
        TRIG_LVL_LO = 3'd1,
        TRIG_RISE   = 3'd2,
        TRIG_FALL   = 3'd3,
        TRIG_BOTH   = 3'd4
    } trig_e;

    // Per-pin configuration word, bit 0 at the bottom
    typedef struct packed {
        logic [2:0] trig;     // 7:5
        logic       spare;    // 4, always zero
        logic       irq_arm;  // 3
        logic       buf_en;   // 2
        logic       in_en;    // 1
        logic       drv_en;   // 0
    } pin_cfg_t;

    function automatic pin_cfg_t cfg_from_word(logic [CFG_W-1:0] w);
        pin_cfg_t c;
        c         = pin_cfg_t'(w);
        c.spare   = 1'b0;
        return c;
    endfunction

    // Event condition for one pin given current and previous synchronized level
    function automatic logic trig_hit(logic [2:0] trig, logic cur, logic prev);
        logic hit;
        case (trig)
            TRIG_LVL_HI: hit = cur;
            TRIG_LVL_LO: hit = ~cur;
            TRIG_RISE:   hit = cur & ~prev;
            TRIG_FALL:   hit = ~cur & prev;
            TRIG_BOTH:   hit = cur ^ prev;
            default:     hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pinbank_pin.sv
module pinbank_pin
    import pinbank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             pad_in,
    input  logic             drive_bit,
    output logic [CFG_W-1:0] cfg_word,
    output logic             pad_out,
    output logic             pad_oe,
    output logic             level,
    output logic             irq_arm,
    output logic             event_hit
);
    pin_cfg_t cfg_q;
    logic     lvl_s;
    logic     prev_q;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_from_word(cfg_wdata);
    end

    pinbank_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (lvl_s)
    );

    // Previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl_s;
    end

    assign cfg_word  = cfg_q;
    assign pad_oe    = cfg_q.drv_en & cfg_q.buf_en;
    assign pad_out   = drive_bit & pad_oe;
    assign level     = lvl_s;
    assign irq_arm   = cfg_q.irq_arm;
    assign event_hit = trig_hit(cfg_q.trig, lvl_s, prev_q);
endmodule

// File: rtl/pinbank_status.sv
module pinbank_status #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] hit,
    input  logic [NUM_PINS-1:0] arm,
    input  logic                clr_we,
    input  logic [NUM_PINS-1:0] clr_mask,
    output logic [NUM_PINS-1:0] pending
);
    logic [NUM_PINS-1:0] clr_eff;
    logic [NUM_PINS-1:0] set_eff;

    assign clr_eff = clr_we ? clr_mask : '0;
    assign set_eff = hit & arm;

    // Set has priority over clear on the same bit
    always_ff @(posedge clk) begin
        if (rst) pending <= '0;
        else     pending <= (pending & ~clr_eff) | set_eff;
    end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_we,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    localparam int PIN_IDX_W = $clog2(NUM_PINS);
    localparam int WORD_W    = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] CFG_END = ADDR_W'(NUM_PINS * 4);

    logic                 aligned;
    logic                 cfg_hit;
    logic                 pend_hit;
    logic                 lvl_hit;
    logic                 drv_hit;
    logic [WORD_W-1:0]    word_idx;
    logic [PIN_IDX_W-1:0] pin_idx;

    logic [NUM_PINS-1:0]  drive_q;
    logic [NUM_PINS-1:0]  pending_q;
    logic [NUM_PINS-1:0]  level_vec;
    logic [NUM_PINS-1:0]  ien_vec;
    logic [NUM_PINS-1:0]  hit_vec;
    logic [CFG_W-1:0]     cfg_words [NUM_PINS];

    // Address decode
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign word_idx = bus_addr[ADDR_W-1:2];
    assign pin_idx  = word_idx[PIN_IDX_W-1:0];
    assign cfg_hit  = aligned && (bus_addr < CFG_END);
    assign pend_hit = (bus_addr == ADDR_W'(OFS_PENDING));
    assign lvl_hit  = (bus_addr == ADDR_W'(OFS_LEVEL));
    assign drv_hit  = (bus_addr == ADDR_W'(OFS_DRIVE));

    // Per-pin slices
    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            logic cfg_we_i;
            assign cfg_we_i = bus_we && cfg_hit && (word_idx == WORD_W'(i));

            pinbank_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
                .clk       (clk),
                .rst       (rst),
                .cfg_we    (cfg_we_i),
                .cfg_wdata (bus_wdata[CFG_W-1:0]),
                .pad_in    (pad_in[i]),
                .drive_bit (drive_q[i]),
                .cfg_word  (cfg_words[i]),
                .pad_out   (pad_out[i]),
                .pad_oe    (pad_oe[i]),
                .level     (level_vec[i]),
                .irq_arm   (ien_vec[i]),
                .event_hit (hit_vec[i])
            );
        end
    endgenerate

    // Drive word
    always_ff @(posedge clk) begin
        if (rst)                  drive_q <= '0;
        else if (bus_we && drv_hit) drive_q <= bus_wdata[NUM_PINS-1:0];
    end

    // Sticky pending word
    pinbank_status #(.NUM_PINS(NUM_PINS)) u_status (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit_vec),
        .arm      (ien_vec),
        .clr_we   (bus_we && pend_hit),
        .clr_mask (bus_wdata[NUM_PINS-1:0]),
        .pending  (pending_q)
    );

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (cfg_hit)       bus_rdata = DATA_W'(cfg_words[pin_idx]);
        else if (pend_hit) bus_rdata = DATA_W'(pending_q);
        else if (lvl_hit)  bus_rdata = DATA_W'(level_vec);
        else if (drv_hit)  bus_rdata = DATA_W'(drive_q);
    end

    assign irq = |(pending_q & ien_vec);
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic                irq,
    input logic [NUM_PINS-1:0] pending,
    input logic [NUM_PINS-1:0] irq_en,
    input logic [NUM_PINS-1:0] hits
);
    logic clr_wr;
    assign clr_wr = bus_we && (bus_addr == ADDR_W'(OFS_PENDING));

    // R1: state right after a reset cycle
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (pending == '0 && pad_oe == '0 && !irq));

    // R3: an output enable only appears after a bus write
    p_oe_after_write_r3: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & ~$past(pad_oe)) != '0) |-> $past(bus_we));

    // R4: pad outputs hold when the bus is idle
    p_out_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_we) |-> $stable(pad_out));

    // R6: a clearing write leaves no named bit set unless an armed event hit it
    p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((pending & $past(bus_wdata[NUM_PINS-1:0]) & ~$past(hits & irq_en)) == '0));

    // R9: a newly set pending bit had its arm bit set
    p_set_needs_arm_r9: assert property (@(posedge clk) disable iff (rst)
        ((pending & ~$past(pending) & ~$past(irq_en)) == '0));
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .irq       (irq),
    .pending   (pending_q),
    .irq_en    (ien_vec),
    .hits      (hit_vec)
);

// File: tb/test_pinbank_ctrl.sv
`timescale 1ns/1ps
module test_pinbank_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pinbank_ctrl i_pinbank_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_pad(input int pin, input logic v);
        @(negedge clk);
        pad_in[pin] = v;
    endtask

    task automatic quiesce();
        pad_in = '0;
        for (int i = 0; i < 32; i++) wr(8'(i * 4), 32'h0);
        repeat (4) @(posedge clk);
        wr(8'h80, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); check("R1 cfg0", d, 0);
        rd(8'h7C, d); check("R1 cfg31", d, 0);
        rd(8'h80, d); check("R1 pending", d, 0);
        rd(8'h88, d); check("R1 drive", d, 0);
        check("R1 pad_oe", pad_oe, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_config();
        logic [31:0] d;
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, d); check("R2 cfg3 kept bits", d, 32'hEF);
        wr(8'h7C, 32'h8A);
        rd(8'h7C, d); check("R2 cfg31", d, 32'h8A);
        quiesce();
    endtask

    task automatic t_pads();
        logic [31:0] d;
        wr(8'h08, 32'h01);              // drive enable only
        wr(8'h88, 32'h4);
        check("R3 oe needs buffer", pad_oe, 0);
        check("R3 pad_out gated", pad_out, 0);
        wr(8'h08, 32'h05);              // drive + buffer
        check("R3 oe active", pad_oe, 32'h4);
        check("R3 pad_out", pad_out, 32'h4);
        rd(8'h88, d); check("R4 drive readback", d, 32'h4);
        wr(8'h88, 32'hA5A5_0004);
        rd(8'h88, d); check("R4 drive readback 2", d, 32'hA5A5_0004);
        wr(8'h08, 32'h02);              // input
        check("R3 input pin not driven", pad_oe, 0);
        wr(8'h88, 32'h0);
        quiesce();
    endtask

    task automatic t_input();
        logic [31:0] d;
        @(negedge clk);
        pad_in = 32'h1234_5678;
        @(posedge clk);
        rd(8'h84, d); check("R5 level after one edge", d, 0);
        @(negedge clk);
        pad_in = 32'h0F0F_8001;
        repeat (2) @(posedge clk);
        rd(8'h84, d); check("R5 level after two edges", d, 32'h0F0F_8001);
        quiesce();
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(8'h10, 32'h0A);              // pin4 level high, armed
        set_pad(4, 1'b1);
        repeat (3) @(posedge clk);
        rd(8'h80, d); check("R7 level high sets", d, 32'h10);
        check("R9 irq on armed pending", {31'b0, irq}, 1);
        wr(8'h80, 32'h10);
        rd(8'h80, d); check("R7 level re-sets after clear", d, 32'h10);
        set_pad(4, 1'b0);
        repeat (4) @(posedge clk);
        wr(8'h80, 32'h10);
        rd(8'h80, d); check("R7 cleared once level gone", d, 0);
        wr(8'h14, 32'h2A);              // pin5 level low, armed, pad low
        repeat (2) @(posedge clk);
        rd(8'h80, d); check("R7 level low sets", d, 32'h20);
        set_pad(5, 1'b1);
        repeat (4) @(posedge clk);
        wr(8'h80, 32'h20);
        rd(8'h80, d); check("R7 level low released", d, 0);
        quiesce();
    endtask

    task automatic t_edges();
        logic [31:0] d;
        wr(8'h18, 32'h4A);              // pin6 rising
        set_pad(6, 1'b1);
        repeat (3) @(posedge clk);
        rd(8'h80, d); check("R8 rising sets", d, 32'h40);
        wr(8'h80, 32'h0);
        rd(8'h80, d); check("R6 zero write keeps bit", d, 32'h40);
        wr(8'h80, 32'h40);
        rd(8'h80, d); check("R6 one write clears", d, 0);
        repeat (3) @(posedge clk);
        rd(8'h80, d); check("R8 rising is one-shot", d, 0);
        set_pad(6, 1'b0);
        repeat (4) @(posedge clk);
        rd(8'h80, d); check("R8 rising ignores fall", d, 0);
        wr(8'h18, 32'h6A);              // falling
        set_pad(6, 1'b1);
        repeat (4) @(posedge clk);
        rd(8'h80, d); check("R8 falling ignores rise", d, 0);
        set_pad(6, 1'b0);
        repeat (3) @(posedge clk);
        rd(8'h80, d); check("R8 falling sets", d, 32'h40);
        wr(8'h18, 32'h8A);              // both
        wr(8'h80, 32'h40);
        set_pad(6, 1'b1);
        repeat (3) @(posedge clk);
        rd(8'h80, d); check("R8 both on rise", d, 32'h40);
        wr(8'h80, 32'h40);
        set_pad(6, 1'b0);
        repeat (3) @(posedge clk);
        rd(8'h80, d); check("R8 both on fall", d, 32'h40);
        quiesce();
    endtask

    task automatic t_arm();
        logic [31:0] d;
        wr(8'h24, 32'h42);              // pin9 rising, not armed
        set_pad(9, 1'b1);
        repeat (4) @(posedge clk);
        rd(8'h80, d); check("R9 unarmed no pending", d, 0);
        check("R9 unarmed no irq", {31'b0, irq}, 0);
        set_pad(9, 1'b0);
        repeat (3) @(posedge clk);
        wr(8'h24, 32'h4A);
        set_pad(9, 1'b1);
        repeat (3) @(posedge clk);
        rd(8'h80, d); check("R9 armed pending", d, 32'h200);
        check("R9 irq high", {31'b0, irq}, 1);
        wr(8'h24, 32'h42);
        check("R9 disarm drops irq", {31'b0, irq}, 0);
        rd(8'h80, d); check("R9 pending kept", d, 32'h200);
        quiesce();
    endtask

    task automatic t_collide();
        logic [31:0] d;
        wr(8'h1C, 32'h4A);              // pin7 rising
        wr(8'h20, 32'h4A);              // pin8 rising
        set_pad(8, 1'b1);
        repeat (3) @(posedge clk);
        rd(8'h80, d); check("R10 setup pin8 pending", d, 32'h100);
        set_pad(7, 1'b1);               // event lands on third rising edge
        @(negedge clk);
        wr(8'h80, 32'h180);             // commits on that same edge
        rd(8'h80, d); check("R10 set wins, other bit cleared", d, 32'h80);
        quiesce();
    endtask

    task automatic t_badcode();
        logic [31:0] d;
        wr(8'h28, 32'hAA);              // code 101
        wr(8'h2C, 32'hEA);              // code 111
        set_pad(10, 1'b1);
        set_pad(11, 1'b1);
        repeat (4) @(posedge clk);
        set_pad(10, 1'b0);
        set_pad(11, 1'b0);
        repeat (4) @(posedge clk);
        rd(8'h80, d); check("R12 reserved codes silent", d, 0);
        quiesce();
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(8'h88, 32'h0000_00F0);
        wr(8'h8C, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        wr(8'h89, 32'hFFFF_FFFF);       // misaligned drive
        wr(8'h01, 32'hFFFF_FFFF);       // misaligned cfg0
        rd(8'h88, d); check("R11 drive untouched", d, 32'hF0);
        rd(8'h00, d); check("R11 cfg0 untouched", d, 0);
        rd(8'h8C, d); check("R11 0x8C reads zero", d, 0);
        rd(8'h89, d); check("R11 misaligned reads zero", d, 0);
        wr(8'h88, 32'h0);
    endtask

    initial begin
        rst       = 1'b1;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_we    = 1'b0;
        pad_in    = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_config();
        t_pads();
        t_input();
        t_level();
        t_edges();
        t_arm();
        t_collide();
        t_badcode();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule